// File: doc/BRIEF.md
# Multi-Mode Output Compare Channel

One output-compare channel watches a free-running timer value supplied from outside and drives a single output pin. Two programmable compare values, A and B, are matched against the timer. A 3-bit mode field selects one of eight behaviours: off, two one-shot edges, a continuous toggle, a single dual-edge pulse, a continuous dual-edge pulse train, edge-aligned PWM and center-aligned PWM.

A trigger-status flag is set by an external trigger pulse. Software can clear it through a control write. When the trigger-mode bit is set, the flag is also cleared by hardware on a compare-B match. Mode, A, B and control are written through one narrow register port. In the two PWM modes, A and B are held in shadow registers and take effect when the timer passes through zero. In every other mode, writes apply at once.

Top module: `oc_channel`

## Requirements
- R1: After reset, the mode is 000, A, B and the trigger-mode bit are 0, and both `pin_out` and `trig_stat` are 0. While the mode is 000, `pin_out` stays 0.
- R2: A mode write (`wr_sel`=0, mode in `wr_data[2:0]`) sets `pin_out` to the starting level of the new mode on the clock that takes the write. The starting level is 1 for mode 010 and 0 for every other mode. The write also restarts the one-shot and pulse sequencing. A mode write has priority over any compare event on the same clock.
- R3: Mode 001: on the first clock where timer equals A, `pin_out` goes to 1. It then stays at 1 until the mode is rewritten.
- R4: Mode 010: on the first clock where timer equals A, `pin_out` goes to 0. It then stays at 0 until the mode is rewritten.
- R5: Mode 011: `pin_out` inverts on every clock where timer equals A.
- R6: Mode 100: the first A match drives `pin_out` to 1. The next B match drives it to 0. After that the channel is idle until the mode is rewritten.
- R7: Mode 101: `pin_out` alternates between an A match that drives it to 1 and a B match that drives it to 0, without end.
- R8: Mode 110: `pin_out` goes to 1 when the timer is 0 and to 0 when the timer equals A. When both hold, 0 wins, so A=0 gives a constant low.
- R9: Mode 111: `pin_out` goes to 1 on an A match and to 0 on a B match. When A equals B, 0 wins.
- R10: In modes 110 and 111, writes to A (`wr_sel`=1) and B (`wr_sel`=2) go to shadow registers. The shadow values become active on a clock where the timer is 0, and they are already used for the compares of that same clock.
- R11: In modes 000 to 101, writes to A and B take effect for compares from the next clock on.
- R12: An `trig_in` pulse sets `trig_stat`. A control write (`wr_sel`=3) with `wr_data[1]`=1 clears it. A clear has priority over a set on the same clock.
- R13: The control write stores `wr_data[0]` as the trigger-mode bit. With the bit at 1, a B match clears `trig_stat`. With the bit at 0, only the software clear does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 mode, 1 compare A, 2 compare B, 3 control |
| wr_data | input | W | Write data |
| tmr | input | W | External timer value |
| trig_in | input | 1 | Trigger pulse that sets the status flag |
| pin_out | output | 1 | Compare output pin |
| trig_stat | output | 1 | Trigger status flag |

## Verification
The embedded assertions check several behaviours on every cycle:
- the pin stays low while the channel is disabled;
- a finished one-shot holds its level;
- a mode-010 write starts high;
- PWM active compare values change only while the timer is zero;
- the status never falls without a clear source.

The exact edge positions in each mode, the shadow-load timing across a period, the priority between a trigger and a clear, and the hardware clear on a B match are shown only by the bench. Its behavioural model is compared with both outputs on every clock while the scenarios walk through all eight modes.

// File: rtl/oc_channel.sv
module oc_channel #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] tmr,
  input  logic         trig_in,
  output logic         pin_out,
  output logic         trig_stat
);

  localparam logic [2:0] M_OFF  = 3'd0;
  localparam logic [2:0] M_SETH = 3'd1;
  localparam logic [2:0] M_SETL = 3'd2;
  localparam logic [2:0] M_TOG  = 3'd3;
  localparam logic [2:0] M_PLS  = 3'd4;
  localparam logic [2:0] M_TRN  = 3'd5;
  localparam logic [2:0] M_EPWM = 3'd6;
  localparam logic [2:0] M_CPWM = 3'd7;

  logic [2:0]   mode_q;
  logic [W-1:0] act_a, act_b, shd_a, shd_b;
  logic         pin_q, done_q, phase_q, tmode_q, tstat_q;

  wire          pwm     = (mode_q[2:1] == 2'b11);
  wire          wrap    = (tmr == '0);
  wire          load    = pwm && wrap;
  wire [W-1:0]  eff_a   = load ? shd_a : act_a;
  wire [W-1:0]  eff_b   = load ? shd_b : act_b;
  wire          hit_a   = (tmr == eff_a);
  wire          hit_b   = (tmr == eff_b);
  wire          wr_mode = wr_en && (wr_sel == 2'd0);
  wire          wr_a    = wr_en && (wr_sel == 2'd1);
  wire          wr_b    = wr_en && (wr_sel == 2'd2);
  wire          wr_ctl  = wr_en && (wr_sel == 2'd3);
  wire          sw_clr  = wr_ctl && wr_data[1];
  wire          hw_clr  = tmode_q && hit_b;

  assign pin_out   = pin_q;
  assign trig_stat = tstat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= M_OFF;
    end else if (wr_mode) begin
      mode_q <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
      shd_a <= '0;
      shd_b <= '0;
    end else begin
      if (load) begin
        act_a <= shd_a;
        act_b <= shd_b;
      end
      if (wr_a) begin
        shd_a <= wr_data;
        if (!pwm) act_a <= wr_data;
      end
      if (wr_b) begin
        shd_b <= wr_data;
        if (!pwm) act_b <= wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmode_q <= 1'b0;
      tstat_q <= 1'b0;
    end else begin
      if (wr_ctl) tmode_q <= wr_data[0];
      if (sw_clr || hw_clr) tstat_q <= 1'b0;
      else if (trig_in) tstat_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (wr_mode) begin
      pin_q   <= (wr_data[2:0] == M_SETL);
      done_q  <= 1'b0;
      phase_q <= 1'b0;
    end else begin
      unique case (mode_q)
        M_OFF: pin_q <= 1'b0;
        M_SETH, M_SETL: begin
          if (!done_q && hit_a) begin
            pin_q  <= (mode_q == M_SETH);
            done_q <= 1'b1;
          end
        end
        M_TOG: if (hit_a) pin_q <= ~pin_q;
        M_PLS, M_TRN: begin
          if (!done_q) begin
            if (!phase_q && hit_a) begin
              pin_q   <= 1'b1;
              phase_q <= 1'b1;
            end else if (phase_q && hit_b) begin
              pin_q   <= 1'b0;
              phase_q <= 1'b0;
              done_q  <= (mode_q == M_PLS);
            end
          end
        end
        M_EPWM: begin
          if (hit_a) pin_q <= 1'b0;
          else if (wrap) pin_q <= 1'b1;
        end
        M_CPWM: begin
          if (hit_b) pin_q <= 1'b0;
          else if (hit_a) pin_q <= 1'b1;
        end
        default: pin_q <= 1'b0;
      endcase
    end
  end

  // R1
  off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_OFF && !wr_mode) |=> !pin_out);

  // R3
  seth_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SETH && done_q && !wr_mode) |=> pin_out);

  // R4
  setl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_SETL && done_q && !wr_mode) |=> !pin_out);

  // R2
  init_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_mode && wr_data[2:0] == M_SETL) |=> pin_out);

  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm && !wrap && !wr_mode) |=> ($stable(act_a) && $stable(act_b)));

  // R13
  stat_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tstat_q && !sw_clr && !tmode_q) |=> trig_stat);

endmodule

// File: tb/oc_channel_bench.sv
module oc_channel_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] tmr = '0;
  logic         trig_in = 1'b0;
  wire          pin_out, trig_stat;

  int total = 0, bad = 0;
  int tcnt = 0, per = 16;
  bit finished = 0;

  always #5 clk = ~clk;

  oc_channel #(.W(W)) u_oc_channel (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tmr(tmr), .trig_in(trig_in), .pin_out(pin_out), .trig_stat(trig_stat));

  // behavioural reference
  int  m_mode, m_a, m_b, s_a, s_b, m_stage;
  bit  m_out, m_ts, m_tm;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_a = 0; m_b = 0; s_a = 0; s_b = 0; m_stage = 0;
      m_out = 0; m_ts = 0; m_tm = 0;
    end else begin
      automatic bit pw = (m_mode >= 6);
      automatic int t  = tmr;
      automatic int ea = (pw && t == 0) ? s_a : m_a;
      automatic int eb = (pw && t == 0) ? s_b : m_b;
      automatic bit ha = (t == ea), hb = (t == eb);
      automatic bit ctl = wr_en && wr_sel == 3;
      if ((ctl && wr_data[1]) || (m_tm && hb)) m_ts = 0;
      else if (trig_in) m_ts = 1;
      if (ctl) m_tm = wr_data[0];
      if (wr_en && wr_sel == 0) begin
        m_mode = wr_data[2:0]; m_out = (m_mode == 2); m_stage = 0;
      end else begin
        case (m_mode)
          0: m_out = 0;
          1, 2: if (m_stage == 0 && ha) begin m_out = (m_mode == 1); m_stage = 9; end
          3: if (ha) m_out = !m_out;
          4, 5: if (m_stage == 0 && ha) begin m_out = 1; m_stage = 1; end
                else if (m_stage == 1 && hb) begin m_out = 0; m_stage = (m_mode == 4) ? 9 : 0; end
          6: if (ha) m_out = 0; else if (t == 0) m_out = 1;
          7: if (hb) m_out = 0; else if (ha) m_out = 1;
          default: ;
        endcase
      end
      if (pw && t == 0) begin m_a = s_a; m_b = s_b; end
      if (wr_en && wr_sel == 1) begin s_a = wr_data; if (!pw) m_a = wr_data; end
      if (wr_en && wr_sel == 2) begin s_b = wr_data; if (!pw) m_b = wr_data; end
    end
  end

  function automatic string tag(int md);
    case (md)
      0: return "R1"; 1: return "R3"; 2: return "R4"; 3: return "R5/R11";
      4: return "R6"; 5: return "R7"; 6: return "R8/R10"; default: return "R9/R10";
    endcase
  endfunction

  task automatic chk(string r, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", r, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(tag(m_mode), pin_out, m_out);
    chk("R12/R13", trig_stat, m_ts);
    tcnt = (tcnt + 1) % per;
    tmr = W'(tcnt);
    wr_en = 0; trig_in = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(int sel, int data);
    wr_en = 1; wr_sel = 2'(sel); wr_data = W'(data);
    tick();
  endtask

  task automatic go_to(int t);
    while (tcnt != t) tick();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", pin_out, 1'b0);
    chk("R1", trig_stat, 1'b0);
    run(3);
    wr(2, 12); wr(1, 5); run(20);
    wr(0, 1); run(40);
    chk("R3", pin_out, 1'b1);
    wr(0, 2);
    chk("R2", pin_out, 1'b1);
    run(40);
    chk("R4", pin_out, 1'b0);
    wr(0, 3); run(24);
    go_to(6); wr(1, 9); run(30);
    wr(1, 5); wr(0, 4); run(50);
    chk("R6", pin_out, 1'b0);
    wr(0, 5); run(50);
    wr(0, 6); run(35);
    go_to(7); wr(1, 10); run(40);
    wr(1, 0); run(40);
    chk("R8", pin_out, 1'b0);
    wr(1, 3); wr(2, 11); wr(0, 7); run(40);
    wr(1, 7); wr(2, 7); run(40);
    chk("R9", pin_out, 1'b0);
    wr(0, 0); run(5);
    trig_in = 1; tick();
    chk("R12", trig_stat, 1'b1);
    trig_in = 1; wr(3, 2);
    chk("R12", trig_stat, 1'b0);
    wr(3, 1); wr(2, 9); trig_in = 1; tick(); run(20);
    chk("R13", trig_stat, 1'b0);
    wr(3, 0); trig_in = 1; tick(); run(20);
    chk("R13", trig_stat, 1'b1);
    run(5);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule